// File: doc/BRIEF.md
# Interrupt Acknowledge Arbitration Controller

This block settles which requester ends an interrupt acknowledge cycle. When an acknowledge cycle opens, it compares the acknowledged priority level with the request level of every internal module. It also checks the programmable level of the periodic timer and the external interrupt pins. Contention runs every time, even when a single source is asking. Among the matching sources, the one with the largest arbitration ID takes the cycle.

A winning internal module, or the periodic timer, supplies its own vector number and the cycle ends with an internal size acknowledge. When the external pins win, the cycle is handed to the external bus interface, which must fetch the vector. If no source contends, or if the winning ID is shared, the cycle ends at once with a bus error. The result is captured one clock after the acknowledge strobe and stays put until the cycle-done strobe.

Top module: `iarb_ctrl`

## Requirements
- R1: After reset, `busy`, `win_src`, `vec_valid`, `vec_out`, `int_dsack`, `ext_fwd`, `bus_err` and `cfg_err` are all zero.
- R2: The result appears on the outputs in the cycle after the clock edge that sees `iack_start` while idle. It is held unchanged while `busy` is high, and all outputs return to zero in the cycle after the edge that sees `iack_done`.
- R3: Arbitration runs even with one requester. A lone internal module whose level equals `iack_level` and whose ID is non-zero wins.
- R4: A source contends only when its level equals `iack_level`, and that level is non-zero. An acknowledge at level 0 always gives a bus error.
- R5: Among the contending sources, the one with the largest 4-bit ID wins. The timer and the pins share the single ID `sys_id`.
- R6: A source whose ID is 0 never contends.
- R7: When no source contends, `bus_err` is 1, `win_src` is 0, and `vec_valid`, `int_dsack` and `ext_fwd` are 0.
- R8: When internal module i wins, `win_src` is i+1, `vec_valid` and `int_dsack` are 1, `vec_out` is that module's vector, and `ext_fwd` is 0.
- R9: A `tmr_lvl` of 000 disables the timer. Any other value is the level at which the timer requests.
- R10: When the system source wins and the timer level matches, the timer is served even if the pin for that level is also asserted. In that case `win_src` is N_MOD+1, `vec_out` is `tmr_vec`, and `vec_valid` and `int_dsack` are 1.
- R11: When the system source wins only through the pins (`irq_pins[iack_level]` high), `win_src` is N_MOD+2, `ext_fwd` is 1, and `vec_valid`, `int_dsack` and `vec_out` are 0.
- R12: When two or more contending sources share the largest ID, `cfg_err` and `bus_err` are 1 and `win_src` is 0.
- R13: An `iack_start` seen while `busy` is high has no effect on the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| iack_start | input | 1 | Acknowledge cycle begins; inputs are sampled at this edge |
| iack_done | input | 1 | Acknowledge cycle completes; result released |
| iack_level | input | LVL_W | Priority level being acknowledged |
| mod_lvl | input | N_MOD*LVL_W | Request level of each internal module, module i at slice i |
| mod_id | input | N_MOD*ID_W | Arbitration ID of each internal module |
| mod_vec | input | N_MOD*VEC_W | Vector number of each internal module |
| sys_id | input | ID_W | Arbitration ID shared by the timer and the pins |
| tmr_lvl | input | LVL_W | Periodic timer level, 0 disables |
| tmr_vec | input | VEC_W | Periodic timer vector number |
| irq_pins | input | 2**LVL_W | External request pins, bit L requests level L, bit 0 unused |
| busy | output | 1 | A result is being held |
| win_src | output | clog2(N_MOD+3) | Winner: 0 none, i+1 module i, N_MOD+1 timer, N_MOD+2 pins |
| vec_valid | output | 1 | vec_out carries an internal vector |
| vec_out | output | VEC_W | Vector number of the internal winner |
| int_dsack | output | 1 | Internal size acknowledge ends the cycle |
| ext_fwd | output | 1 | Cycle handed to the external bus |
| bus_err | output | 1 | Cycle ends with a bus error |
| cfg_err | output | 1 | Winning ID was shared by several contenders |

## Verification
The assertions assume that the request inputs only matter at the sampling edge of `iack_start`. They also assume that `iack_done` is only raised while a result is held. The stimulus keeps to this by changing inputs on the falling edge, holding them until the result has been captured, and raising `iack_done` only after the captured result has been checked. Random IDs are drawn from a small pool, so equal IDs and ID 0 both occur. Levels are biased toward the acknowledged level, so contention is frequent.

// File: rtl/iarb_pkg.sv
package iarb_pkg;
    typedef enum logic {ST_IDLE, ST_HOLD} iarb_st_e;

    typedef struct packed {
        logic vld;
        logic dsack;
        logic fwd;
        logic berr;
        logic cfg;
    } iarb_flags_t;
endpackage

// File: rtl/iarb_contend.sv
module iarb_contend #(
    parameter int N_MOD = 4,
    parameter int LVL_W = 3,
    parameter int ID_W  = 4
) (
    input  logic [LVL_W-1:0]       ack_lvl,
    input  logic [N_MOD*LVL_W-1:0] mod_lvl,
    input  logic [N_MOD*ID_W-1:0]  mod_id,
    input  logic [ID_W-1:0]        sys_id,
    input  logic [LVL_W-1:0]       tmr_lvl,
    input  logic [(1<<LVL_W)-1:0]  irq_pins,
    output logic [N_MOD:0]         cont,
    output logic [(N_MOD+1)*ID_W-1:0] ids,
    output logic                   tmr_hit,
    output logic                   pin_hit
);
    logic lvl_live;
    assign lvl_live = (ack_lvl != '0);

    for (genvar g = 0; g < N_MOD; g++) begin : g_mod
        logic [LVL_W-1:0] lvl_g;
        logic [ID_W-1:0]  id_g;
        assign lvl_g = mod_lvl[g*LVL_W +: LVL_W];
        assign id_g  = mod_id[g*ID_W +: ID_W];
        assign cont[g] = lvl_live && (lvl_g == ack_lvl) && (id_g != '0);
        assign ids[g*ID_W +: ID_W] = id_g;
    end

    assign tmr_hit = lvl_live && (tmr_lvl != '0) && (tmr_lvl == ack_lvl);
    assign pin_hit = lvl_live && irq_pins[ack_lvl];
    assign cont[N_MOD] = (tmr_hit || pin_hit) && (sys_id != '0);
    assign ids[N_MOD*ID_W +: ID_W] = sys_id;
endmodule

// File: rtl/iarb_pick.sv
module iarb_pick #(
    parameter int N_SRC = 5,
    parameter int ID_W  = 4,
    localparam int IDX_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
    input  logic [N_SRC-1:0]      cont,
    input  logic [N_SRC*ID_W-1:0] ids,
    output logic                  any,
    output logic [IDX_W-1:0]      win_idx,
    output logic                  dup
);
    logic [ID_W-1:0] best_id;

    always_comb begin
        best_id = '0;
        win_idx = '0;
        dup     = 1'b0;
        any     = 1'b0;
        for (int i = 0; i < N_SRC; i++) begin
            if (cont[i]) begin
                if (!any || ids[i*ID_W +: ID_W] > best_id) begin
                    best_id = ids[i*ID_W +: ID_W];
                    win_idx = IDX_W'(i);
                    dup     = 1'b0;
                    any     = 1'b1;
                end else if (ids[i*ID_W +: ID_W] == best_id) begin
                    dup = 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/iarb_ctrl.sv
module iarb_ctrl #(
    parameter int N_MOD = 4,
    parameter int LVL_W = 3,
    parameter int ID_W  = 4,
    parameter int VEC_W = 8,
    localparam int SRC_W = $clog2(N_MOD + 3)
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   iack_start,
    input  logic                   iack_done,
    input  logic [LVL_W-1:0]       iack_level,
    input  logic [N_MOD*LVL_W-1:0] mod_lvl,
    input  logic [N_MOD*ID_W-1:0]  mod_id,
    input  logic [N_MOD*VEC_W-1:0] mod_vec,
    input  logic [ID_W-1:0]        sys_id,
    input  logic [LVL_W-1:0]       tmr_lvl,
    input  logic [VEC_W-1:0]       tmr_vec,
    input  logic [(1<<LVL_W)-1:0]  irq_pins,
    output logic                   busy,
    output logic [SRC_W-1:0]       win_src,
    output logic                   vec_valid,
    output logic [VEC_W-1:0]       vec_out,
    output logic                   int_dsack,
    output logic                   ext_fwd,
    output logic                   bus_err,
    output logic                   cfg_err
);
    import iarb_pkg::*;

    localparam int N_SRC = N_MOD + 1;
    localparam int IDX_W = $clog2(N_SRC);

    typedef struct packed {
        iarb_st_e        st;
        logic [SRC_W-1:0] src;
        logic [VEC_W-1:0] vec;
        iarb_flags_t     fl;
    } iarb_reg_t;

    logic [N_SRC-1:0]      cont;
    logic [N_SRC*ID_W-1:0] ids;
    logic                  tmr_hit, pin_hit;
    logic                  any, dup;
    logic [IDX_W-1:0]      win_idx;
    iarb_reg_t             r_d, r_q;

    iarb_contend #(.N_MOD(N_MOD), .LVL_W(LVL_W), .ID_W(ID_W)) u_contend (
        .ack_lvl (iack_level),
        .mod_lvl (mod_lvl),
        .mod_id  (mod_id),
        .sys_id  (sys_id),
        .tmr_lvl (tmr_lvl),
        .irq_pins(irq_pins),
        .cont    (cont),
        .ids     (ids),
        .tmr_hit (tmr_hit),
        .pin_hit (pin_hit)
    );

    iarb_pick #(.N_SRC(N_SRC), .ID_W(ID_W)) u_pick (
        .cont   (cont),
        .ids    (ids),
        .any    (any),
        .win_idx(win_idx),
        .dup    (dup)
    );

    always_comb begin
        int widx;
        r_d  = r_q;
        widx = int'(win_idx);
        unique case (r_q.st)
            ST_IDLE: begin
                if (iack_start) begin
                    r_d     = '0;
                    r_d.st  = ST_HOLD;
                    if (!any || dup) begin
                        r_d.fl.berr = 1'b1;
                        r_d.fl.cfg  = any && dup;
                    end else if (widx < N_MOD) begin
                        r_d.src      = SRC_W'(widx + 1);
                        r_d.vec      = mod_vec[widx*VEC_W +: VEC_W];
                        r_d.fl.vld   = 1'b1;
                        r_d.fl.dsack = 1'b1;
                    end else if (tmr_hit) begin
                        r_d.src      = SRC_W'(N_MOD + 1);
                        r_d.vec      = tmr_vec;
                        r_d.fl.vld   = 1'b1;
                        r_d.fl.dsack = 1'b1;
                    end else begin
                        r_d.src    = SRC_W'(N_MOD + 2);
                        r_d.fl.fwd = pin_hit;
                    end
                end
            end
            ST_HOLD: begin
                if (iack_done) begin
                    r_d = '0;
                end
            end
            default: r_d = '0;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign busy      = (r_q.st == ST_HOLD);
    assign win_src   = r_q.src;
    assign vec_out   = r_q.vec;
    assign vec_valid = r_q.fl.vld;
    assign int_dsack = r_q.fl.dsack;
    assign ext_fwd   = r_q.fl.fwd;
    assign bus_err   = r_q.fl.berr;
    assign cfg_err   = r_q.fl.cfg;
endmodule

// File: rtl/iarb_chk.sv
module iarb_chk #(
    parameter int N_MOD = 4,
    parameter int VEC_W = 8,
    localparam int SRC_W = $clog2(N_MOD + 3)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             iack_start,
    input logic             iack_done,
    input logic             busy,
    input logic [SRC_W-1:0] win_src,
    input logic             vec_valid,
    input logic [VEC_W-1:0] vec_out,
    input logic             int_dsack,
    input logic             ext_fwd,
    input logic             bus_err,
    input logic             cfg_err
);
    // R2
    busy_from_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(iack_start));
    // R13
    hold_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !iack_done) |=> (busy && $stable({win_src, vec_out, vec_valid,
                                   int_dsack, ext_fwd, bus_err, cfg_err})));
    // R2
    release_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && iack_done) |=> (!busy && !int_dsack && !ext_fwd && !bus_err));
    // R7
    one_ending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> $onehot({int_dsack, ext_fwd, bus_err}));
    // R1
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> ({int_dsack, ext_fwd, bus_err, vec_valid, cfg_err} == '0));
    // R8
    vec_with_dsack_chk: assert property (@(posedge clk) disable iff (!rst_n)
        vec_valid == int_dsack);
    // R12
    cfg_means_error_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (bus_err && win_src == '0));
    // R11
    fwd_from_pins_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ext_fwd |-> (win_src == SRC_W'(N_MOD + 2)));
endmodule

bind iarb_ctrl iarb_chk #(.N_MOD(N_MOD), .VEC_W(VEC_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .iack_start(iack_start),
    .iack_done (iack_done),
    .busy      (busy),
    .win_src   (win_src),
    .vec_valid (vec_valid),
    .vec_out   (vec_out),
    .int_dsack (int_dsack),
    .ext_fwd   (ext_fwd),
    .bus_err   (bus_err),
    .cfg_err   (cfg_err)
);

// File: tb/tb_iarb_ctrl.sv
module tb_iarb_ctrl;
    localparam int N = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic iack_start = 1'b0, iack_done = 1'b0;
    logic [2:0] iack_level = '0;
    logic [2:0] m_lvl [N];
    logic [3:0] m_id  [N];
    logic [7:0] m_vec [N];
    logic [N*3-1:0] mod_lvl;
    logic [N*4-1:0] mod_id;
    logic [N*8-1:0] mod_vec;
    logic [3:0] sys_id = '0;
    logic [2:0] tmr_lvl = '0;
    logic [7:0] tmr_vec = '0;
    logic [7:0] irq_pins = '0;
    logic busy, vec_valid, int_dsack, ext_fwd, bus_err, cfg_err;
    logic [2:0] win_src;
    logic [7:0] vec_out;

    int total = 0, bad = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            mod_lvl[i*3 +: 3] = m_lvl[i];
            mod_id[i*4 +: 4]  = m_id[i];
            mod_vec[i*8 +: 8] = m_vec[i];
        end
    end

    iarb_ctrl dut (
        .clk(clk), .rst_n(rst_n), .iack_start(iack_start), .iack_done(iack_done),
        .iack_level(iack_level), .mod_lvl(mod_lvl), .mod_id(mod_id), .mod_vec(mod_vec),
        .sys_id(sys_id), .tmr_lvl(tmr_lvl), .tmr_vec(tmr_vec), .irq_pins(irq_pins),
        .busy(busy), .win_src(win_src), .vec_valid(vec_valid), .vec_out(vec_out),
        .int_dsack(int_dsack), .ext_fwd(ext_fwd), .bus_err(bus_err), .cfg_err(cfg_err)
    );

    // {busy, cfg, berr, fwd, dsack, vld, src[2:0], vec[7:0]}
    function automatic logic [16:0] got();
        return {busy, cfg_err, bus_err, ext_fwd, int_dsack, vec_valid, win_src, vec_out};
    endfunction

    function automatic logic [16:0] expect_word();
        bit   c [N+1];
        int   idv [N+1];
        int   top_id = -1, n_top = 0, who = -1;
        bit   t_on, p_on;
        t_on = (iack_level != 0) && (tmr_lvl != 0) && (tmr_lvl == iack_level);
        p_on = (iack_level != 0) && irq_pins[iack_level];
        for (int i = 0; i < N; i++) begin
            c[i]   = (iack_level != 0) && (m_lvl[i] == iack_level) && (m_id[i] != 0);
            idv[i] = m_id[i];
        end
        c[N]   = (t_on || p_on) && (sys_id != 0);
        idv[N] = sys_id;
        for (int i = 0; i <= N; i++) if (c[i] && idv[i] > top_id) top_id = idv[i];
        for (int i = 0; i <= N; i++) if (c[i] && idv[i] == top_id) begin n_top++; who = i; end
        if (n_top == 0) return {1'b1, 1'b0, 1'b1, 3'b000, 3'd0, 8'd0};
        if (n_top > 1)  return {1'b1, 1'b1, 1'b1, 3'b000, 3'd0, 8'd0};
        if (who < N)    return {1'b1, 2'b00, 1'b0, 2'b11, 3'(who + 1), m_vec[who]};
        if (t_on)       return {1'b1, 2'b00, 1'b0, 2'b11, 3'(N + 1), tmr_vec};
        return {1'b1, 2'b00, 1'b1, 2'b00, 3'(N + 2), 8'd0};
    endfunction

    task automatic check(string req, logic [16:0] act, logic [16:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic clear_srcs();
        for (int i = 0; i < N; i++) begin m_lvl[i] = 0; m_id[i] = 0; m_vec[i] = 8'h10 + 8'(i); end
        sys_id = 0; tmr_lvl = 0; tmr_vec = 8'h40; irq_pins = 0;
    endtask

    // Starts a cycle, checks the held result, optionally pokes start while busy, releases.
    task automatic run_ack(string req, bit poke);
        logic [16:0] exp;
        exp = expect_word();
        @(negedge clk); iack_start = 1'b1;
        @(negedge clk); iack_start = 1'b0;
        check(req, got(), exp);
        if (poke) begin
            iack_level = iack_level + 3'd1; sys_id = 4'hF; irq_pins = 8'hFE;
            iack_start = 1'b1;
            @(negedge clk); iack_start = 1'b0;
            @(negedge clk);
            check("R13", got(), exp);
        end
        iack_done = 1'b1;
        @(negedge clk); iack_done = 1'b0;
        check("R2", got(), 17'd0);
    endtask

    initial begin
        void'($urandom(32'd1234));
        clear_srcs();
        repeat (3) @(negedge clk);
        check("R1", got(), 17'd0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", got(), 17'd0);

        // R3 lone module
        clear_srcs(); iack_level = 3; m_lvl[2] = 3; m_id[2] = 5;
        run_ack("R3", 1'b0);
        // R4 level mismatch
        clear_srcs(); iack_level = 4; m_lvl[1] = 3; m_id[1] = 7;
        run_ack("R4", 1'b0);
        // R4 level 0 acknowledge
        clear_srcs(); iack_level = 0; m_lvl[1] = 0; m_id[1] = 7;
        run_ack("R4", 1'b0);
        // R5 highest ID, R8 vector
        clear_srcs(); iack_level = 6;
        for (int i = 0; i < N; i++) begin m_lvl[i] = 6; m_id[i] = 4'(i + 2); end
        m_id[1] = 12; sys_id = 9; irq_pins[6] = 1;
        run_ack("R5", 1'b0);
        run_ack("R8", 1'b0);
        // R6 ID 0
        clear_srcs(); iack_level = 2; m_lvl[0] = 2; m_id[0] = 0;
        run_ack("R6", 1'b0);
        // R7 nothing at all
        clear_srcs(); iack_level = 5;
        run_ack("R7", 1'b0);
        // R9 timer disabled, pins idle
        clear_srcs(); iack_level = 1; tmr_lvl = 0; sys_id = 3;
        run_ack("R9", 1'b0);
        // R9 timer enabled at level 1
        tmr_lvl = 1;
        run_ack("R9", 1'b0);
        // R10 timer beats pins at equal level
        clear_srcs(); iack_level = 7; tmr_lvl = 7; irq_pins[7] = 1; sys_id = 8; tmr_vec = 8'hA5;
        m_lvl[3] = 7; m_id[3] = 2;
        run_ack("R10", 1'b0);
        // R11 pins only
        clear_srcs(); iack_level = 4; irq_pins[4] = 1; sys_id = 6; tmr_lvl = 2;
        run_ack("R11", 1'b0);
        // R12 shared winning ID
        clear_srcs(); iack_level = 3; m_lvl[0] = 3; m_lvl[2] = 3; m_id[0] = 9; m_id[2] = 9;
        run_ack("R12", 1'b0);
        // R12 module shares ID with system source
        clear_srcs(); iack_level = 3; m_lvl[1] = 3; m_id[1] = 4; irq_pins[3] = 1; sys_id = 4;
        run_ack("R12", 1'b0);
        // R13 start while busy
        clear_srcs(); iack_level = 2; m_lvl[3] = 2; m_id[3] = 1;
        run_ack("R13", 1'b1);

        // random mix (R5, R7, R10, R11, R12)
        for (int k = 0; k < 400; k++) begin
            iack_level = 3'($urandom % 8);
            for (int i = 0; i < N; i++) begin
                m_lvl[i] = ($urandom % 2) ? iack_level : 3'($urandom % 8);
                m_id[i]  = 4'($urandom % 6);
                m_vec[i] = 8'($urandom);
            end
            sys_id   = 4'($urandom % 6);
            tmr_lvl  = ($urandom % 3 == 0) ? iack_level : 3'($urandom % 8);
            tmr_vec  = 8'($urandom);
            irq_pins = 8'($urandom);
            run_ack("R5", (k % 50) == 0);
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog act=hung exp=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule